// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This unit turns the outcome of a floating-point comparison into a condition bit. An upstream magnitude comparator supplies the relation flags for the two operands: less, equal and unordered. It also flags when either operand is a signalling NaN. The unit decodes a 6-bit compare function code and works out whether the requested predicate holds. It writes the answer into one of eight condition-code bits and raises invalid-operation toward the status logic.

Function codes 48 through 63 are compares; all other codes are ignored. The low three bits of the code pick a set of relations, and the predicate is true when any relation in that set holds. Bit 3 of the code selects the signalling form, in which an unordered comparison is itself invalid. When the invalid exception meets an enabled trap, the condition bit is left as it was.

Top module: `fp_cmp_pred`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cc_out`, `res_valid`, `res_true`, `inv_raise` and `inv_trap` are all 0.
- R2: A compare is accepted when `cmp_valid` is 1 and `cmp_func[5:4]` is 2'b11 (codes 48..63). Its result is due on the outputs in the cycle after the accepting clock edge, with `res_valid` high for that one cycle.
- R3: For an accepted compare, `res_true` is 1 exactly when one of these holds: `cmp_func[0]` is set and the operands are unordered; `cmp_func[1]` is set and they are equal; `cmp_func[2]` is set and the first is less than the second.
- R4: When `rel_un` is 1, the inputs `rel_lt` and `rel_eq` have no effect, so a code with `cmp_func[0]` clear yields false.
- R5: When `cmp_func[3]` is 1 (signalling form) and `rel_un` is 1, `inv_raise` is 1.
- R6: For the quiet form (`cmp_func[3]` = 0), `inv_raise` is 1 only when `any_snan` is 1.
- R7: The accepted compare writes condition bit `cmp_fd[4:2]` with the value of `res_true`. The other seven bits keep their values.
- R8: If `inv_raise` and `inv_trap_en` are both 1 for a compare, `inv_trap` is 1 and `cc_out` is unchanged.
- R9: If `cmp_valid` is 0 or the function code is below 48, `res_valid`, `res_true`, `inv_raise` and `inv_trap` are 0 in the next cycle, and `cc_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Operation strobe |
| cmp_func | input | 6 | Function code; 48..63 are compares |
| cmp_fd | input | 5 | Destination field; bits [4:2] pick the condition bit |
| rel_lt | input | 1 | First operand is less than second |
| rel_eq | input | 1 | Operands are equal |
| rel_un | input | 1 | Operands are unordered (a NaN is present) |
| any_snan | input | 1 | Either operand is a signalling NaN |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| cc_out | output | 8 | Condition-code bits |
| res_valid | output | 1 | Result of an accepted compare is present |
| res_true | output | 1 | Predicate outcome |
| inv_raise | output | 1 | Invalid-operation cause |
| inv_trap | output | 1 | Invalid exception hit an enabled trap |

## Verification
All outputs are registered once. A compare driven before an edge shows its predicate, exception flags and any condition-bit change in the cycle that follows that edge. The bench drives each operation on a falling edge and samples every output on the next falling edge. At that point exactly one rising edge separates stimulus from result. It sweeps every function code against every relation pattern, destination and trap setting. It keeps its own copy of the eight condition bits to compare against.

// File: rtl/fp_cmp_pred.sv
module fp_cmp_pred #(
  parameter int FUNC_W   = 6,
  parameter int CC_COUNT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid,
  input  logic [FUNC_W-1:0]   cmp_func,
  input  logic [4:0]          cmp_fd,
  input  logic                rel_lt,
  input  logic                rel_eq,
  input  logic                rel_un,
  input  logic                any_snan,
  input  logic                inv_trap_en,
  output logic [CC_COUNT-1:0] cc_out,
  output logic                res_valid,
  output logic                res_true,
  output logic                inv_raise,
  output logic                inv_trap
);
  localparam int SEL_W = $clog2(CC_COUNT);

  logic [3:0]       op;
  logic             is_cmp, accept, lt_o, eq_o, pred, inv, trap;
  logic [SEL_W-1:0] sel;

  assign op     = cmp_func[3:0];
  assign is_cmp = (cmp_func[FUNC_W-1:4] == '1);
  assign accept = cmp_valid & is_cmp;

  assign lt_o = rel_lt & ~rel_un;
  assign eq_o = rel_eq & ~rel_un;
  assign pred = (op[0] & rel_un) | (op[1] & eq_o) | (op[2] & lt_o);

  assign inv  = (op[3] & rel_un) | any_snan;
  assign trap = inv & inv_trap_en;
  assign sel  = cmp_fd[2 +: SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_out    <= '0;
      res_valid <= 1'b0;
      res_true  <= 1'b0;
      inv_raise <= 1'b0;
      inv_trap  <= 1'b0;
    end else begin
      res_valid <= accept;
      res_true  <= accept & pred;
      inv_raise <= accept & inv;
      inv_trap  <= accept & trap;
      if (accept && !trap)
        cc_out[sel] <= pred;
    end
  end
endmodule

// File: rtl/fp_cmp_pred_chk.sv
module fp_cmp_pred_chk #(
  parameter int FUNC_W   = 6,
  parameter int CC_COUNT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_valid,
  input logic [FUNC_W-1:0]   cmp_func,
  input logic                rel_un,
  input logic [CC_COUNT-1:0] cc_out,
  input logic                res_valid,
  input logic                res_true,
  input logic                inv_raise,
  input logic                inv_trap
);
  logic cmp_in;
  assign cmp_in = cmp_valid && (cmp_func[FUNC_W-1:4] == '1);

  assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_true || inv_raise || inv_trap) |-> res_valid);

  assert_unordered_ordered_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_in && rel_un && !cmp_func[0]) |=> !res_true);

  assert_signalling_unordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_in && rel_un && cmp_func[3]) |=> inv_raise);

  assert_single_cc_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_out ^ $past(cc_out)) <= 1);

  assert_trap_keeps_cc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_trap |-> ($stable(cc_out) && inv_raise));

  assert_idle_keeps_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(cc_out));
endmodule

bind fp_cmp_pred fp_cmp_pred_chk #(.FUNC_W(FUNC_W), .CC_COUNT(CC_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_func(cmp_func),
  .rel_un(rel_un), .cc_out(cc_out), .res_valid(res_valid), .res_true(res_true),
  .inv_raise(inv_raise), .inv_trap(inv_trap)
);

// File: tb/sim_fp_cmp_pred.sv
module sim_fp_cmp_pred;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_valid = 1'b0;
  logic [5:0] cmp_func = '0;
  logic [4:0] cmp_fd = '0;
  logic       rel_lt = 1'b0, rel_eq = 1'b0, rel_un = 1'b0, any_snan = 1'b0;
  logic       inv_trap_en = 1'b0;
  logic [7:0] cc_out;
  logic       res_valid, res_true, inv_raise, inv_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fp_cmp_pred u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_func(cmp_func),
    .cmp_fd(cmp_fd), .rel_lt(rel_lt), .rel_eq(rel_eq), .rel_un(rel_un),
    .any_snan(any_snan), .inv_trap_en(inv_trap_en), .cc_out(cc_out),
    .res_valid(res_valid), .res_true(res_true), .inv_raise(inv_raise),
    .inv_trap(inv_trap)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] model_cc;
    model_cc = '0;
    repeat (3) @(negedge clk);
    check("R1 cc in reset", cc_out, 8'h00);
    check("R1 flags in reset", {4'b0, res_valid, res_true, inv_raise, inv_trap}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cc after reset", cc_out, 8'h00);
    check("R1 flags after reset", {4'b0, res_valid, res_true, inv_raise, inv_trap}, 8'h00);

    // R9: valid low with a compare code pending
    cmp_func = 6'd63; rel_un = 1'b1; any_snan = 1'b1; cmp_fd = 5'd4;
    @(negedge clk);
    check("R9 idle flags", {4'b0, res_valid, res_true, inv_raise, inv_trap}, 8'h00);
    check("R9 idle cc", cc_out, model_cc);

    for (int tr = 0; tr < 2; tr++)
      for (int f = 0; f < 64; f++)
        for (int r = 0; r < 16; r++)
          for (int d = 0; d < 8; d++) begin
            bit acc, u, e, l, s, sig, pt, iv, tp;
            logic [3:0] op;
            op = f[3:0];
            u = r[0]; e = r[1]; l = r[2]; s = r[3];
            acc = (f >= 48);
            pt  = u ? op[0] : ((e && op[1]) || (l && op[2]));
            sig = op[3];
            iv  = (sig && u) || s;
            tp  = iv && (tr == 1);
            cmp_valid = 1'b1; cmp_func = f[5:0];
            cmp_fd = {d[2:0], 2'(f)};
            rel_un = u; rel_eq = e; rel_lt = l; any_snan = s;
            inv_trap_en = tr[0];
            @(negedge clk);
            cmp_valid = 1'b0;
            if (acc) begin
              check("R2 res_valid", {7'b0, res_valid}, 8'h01);
              check(u ? "R4 res_true unordered" : "R3 res_true", {7'b0, res_true}, {7'b0, pt});
              check(sig ? "R5 inv_raise" : "R6 inv_raise", {7'b0, inv_raise}, {7'b0, iv});
              check("R8 inv_trap", {7'b0, inv_trap}, {7'b0, tp});
              if (!tp) model_cc[d] = pt;
              check(tp ? "R8 cc held" : "R7 cc update", cc_out, model_cc);
            end else begin
              check("R9 non-compare flags", {4'b0, res_valid, res_true, inv_raise, inv_trap}, 8'h00);
              check("R9 non-compare cc", cc_out, model_cc);
            end
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule